// File: doc/BRIEF.md
# Saturating Activation Lookup Table

This block turns a 16-bit signed fixed-point value (eight integer bits, eight fraction bits) into a 16-bit activation output by reading a table that software fills. Because the table holds whatever values were written, the same hardware serves a straight-line transfer, a sigmoid-like curve or any other shape. The table has 4096 entries and covers only the central part of the input range. Inputs beyond that part on either side are clamped to one of two programmable saturation values and do not read the table at all. This cuts the storage to one sixteenth of a full 16-bit-indexed table.

A lookup is offered with a valid strobe and returns two cycles later with its own valid strobe. A new lookup can enter every cycle. A single write port loads table entries and both saturation values, and a two-bit kind field selects the target.

Top module: `act_sat_lut`

## Requirements
- R1: While reset is asserted and for the first two cycles after it, resultValid is low. Reset sets the positive saturation value to 16'h0100 and the negative saturation value to 16'hFF00.
- R2: An input whose bits [15:11] are all equal is in range (-8.0 up to just under +8.0). It returns the table entry at address lookupIn[11:0].
- R3: An input that is not in range and has bit 15 clear returns the positive saturation value, whatever the table holds.
- R4: An input that is not in range and has bit 15 set returns the negative saturation value, whatever the table holds.
- R5: resultValid is high exactly two cycles after the cycle in which lookupValid was high, and is low otherwise. In-range and saturated lookups have the same latency.
- R6: Lookups presented on consecutive cycles each produce a result, in order, on consecutive cycles.
- R7: The write kind selects the target: 2'b00 writes table entry wrAddr, 2'b01 writes the positive saturation value, 2'b10 writes the negative saturation value. 2'b11 changes nothing.
- R8: A write presented in the same cycle as a lookup is not seen by that lookup, which returns the old table entry or the old saturation value. The next lookup sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A lookup is presented this cycle |
| lookupIn | input | 16 | Pre-activation value, signed 8.8 |
| wrEn | input | 1 | Write strobe |
| wrKind | input | 2 | Write target: 00 table, 01 positive saturation, 10 negative saturation, 11 none |
| wrAddr | input | 12 | Table address for a table write |
| wrData | input | 16 | Value to write |
| resultValid | output | 1 | resultOut holds a lookup result |
| resultOut | output | 16 | Activation output |

## Verification
The hardest case to reach is a write and a lookup that meet in the same cycle, because the lookup must return the value from before the write. The bench presents a table write and a lookup of the same address on one cycle, and does the same for a saturation update with a saturated input. It then repeats each lookup alone on the next cycle to show that the new value has arrived. Inputs at the edges of the range, such as 16'h07FF, 16'h0800, 16'hF800 and 16'hF7FF, are sent back to back so that saturated and in-range results alternate in the pipeline.

// File: rtl/act_lut_pkg.sv
package act_lut_pkg;
  typedef enum logic [1:0] {
    WR_TABLE = 2'b00,
    WR_POS   = 2'b01,
    WR_NEG   = 2'b10,
    WR_NONE  = 2'b11
  } wrKind_e;

  typedef struct packed {
    logic tblWr;
    logic posWr;
    logic negWr;
    logic rdEn;
    logic satSel;
    logic satPos;
  } ctrlStrobe_t;
endpackage

// File: rtl/act_lut_ctrl.sv
module act_lut_ctrl
  import act_lut_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              lookupValid,
  input  logic [DATA_W-1:0] lookupIn,
  input  logic              wrEn,
  input  logic [1:0]        wrKind,
  output ctrlStrobe_t       strb
);
  localparam int HI_W = DATA_W - ADDR_W + 1;

  logic [HI_W-1:0] upperBits;
  logic            inRange;
  wrKind_e         kind;

  assign upperBits = lookupIn[DATA_W-1:ADDR_W-1];
  assign inRange   = (&upperBits) | ~(|upperBits);
  assign kind      = wrKind_e'(wrKind);

  always_comb begin
    strb        = '0;
    strb.tblWr  = wrEn && (kind == WR_TABLE);
    strb.posWr  = wrEn && (kind == WR_POS);
    strb.negWr  = wrEn && (kind == WR_NEG);
    strb.rdEn   = lookupValid && inRange;
    strb.satSel = !inRange;
    strb.satPos = !lookupIn[DATA_W-1];
  end
endmodule

// File: rtl/act_lut_datapath.sv
module act_lut_datapath
  import act_lut_pkg::*;
#(
  parameter int              DATA_W       = 16,
  parameter int              ADDR_W       = 12,
  parameter logic [DATA_W-1:0] POS_SAT_INIT = 16'h0100,
  parameter logic [DATA_W-1:0] NEG_SAT_INIT = 16'hFF00
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultOut,
  output logic [DATA_W-1:0] posSatQ,
  output logic [DATA_W-1:0] negSatQ
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] tbl [DEPTH];
  logic [DATA_W-1:0] rdData;

  // table port: read returns the entry held before any same-edge write
  always_ff @(posedge clk) begin
    if (strb.tblWr) tbl[wrAddr] <= wrData;
    if (strb.rdEn)  rdData      <= tbl[lookupAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posSatQ <= POS_SAT_INIT;
      negSatQ <= NEG_SAT_INIT;
    end else begin
      if (strb.posWr) posSatQ <= wrData;
      if (strb.negWr) negSatQ <= wrData;
    end
  end

  // stage 1: range decision and saturation value travel with the read
  logic              validS1;
  logic              satSelS1;
  logic [DATA_W-1:0] satValS1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validS1  <= 1'b0;
      satSelS1 <= 1'b0;
      satValS1 <= '0;
    end else begin
      validS1  <= lookupValid;
      satSelS1 <= strb.satSel;
      satValS1 <= strb.satPos ? posSatQ : negSatQ;
    end
  end

  // stage 2: output register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      resultOut   <= '0;
    end else begin
      resultValid <= validS1;
      if (validS1) resultOut <= satSelS1 ? satValS1 : rdData;
    end
  end
endmodule

// File: rtl/act_sat_lut.sv
module act_sat_lut
  import act_lut_pkg::*;
#(
  parameter int              DATA_W       = 16,
  parameter int              ADDR_W       = 12,
  parameter logic [DATA_W-1:0] POS_SAT_INIT = 16'h0100,
  parameter logic [DATA_W-1:0] NEG_SAT_INIT = 16'hFF00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [DATA_W-1:0] lookupIn,
  input  logic              wrEn,
  input  logic [1:0]        wrKind,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultOut
);
  ctrlStrobe_t       strb;
  logic [DATA_W-1:0] posSatQ;
  logic [DATA_W-1:0] negSatQ;

  act_lut_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .lookupValid (lookupValid),
    .lookupIn    (lookupIn),
    .wrEn        (wrEn),
    .wrKind      (wrKind),
    .strb        (strb)
  );

  act_lut_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .POS_SAT_INIT(POS_SAT_INIT), .NEG_SAT_INIT(NEG_SAT_INIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .lookupValid (lookupValid),
    .lookupAddr  (lookupIn[ADDR_W-1:0]),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .resultValid (resultValid),
    .resultOut   (resultOut),
    .posSatQ     (posSatQ),
    .negSatQ     (negSatQ)
  );
endmodule

// File: rtl/act_sat_lut_chk.sv
module act_sat_lut_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              lookupValid,
  input logic [DATA_W-1:0] lookupIn,
  input logic              wrEn,
  input logic [1:0]        wrKind,
  input logic              resultValid,
  input logic [DATA_W-1:0] resultOut,
  input logic [DATA_W-1:0] posSatQ,
  input logic [DATA_W-1:0] negSatQ
);
  logic [1:0] sinceRst;
  logic       chkInRange;

  assign chkInRange = (&lookupIn[DATA_W-1:ADDR_W-1]) | ~(|lookupIn[DATA_W-1:ADDR_W-1]);

  always_ff @(posedge clk) begin
    if (!rstN)                sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < 2'd2) |-> !resultValid);

  p_valid_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> (resultValid == $past(lookupValid, 2)));

  p_pos_sat_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && !chkInRange && !lookupIn[DATA_W-1])
      |=> ##1 (resultValid && resultOut == $past(posSatQ, 2)));

  p_neg_sat_r4: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && !chkInRange && lookupIn[DATA_W-1])
      |=> ##1 (resultValid && resultOut == $past(negSatQ, 2)));

  p_reserved_kind_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrKind == 2'b11) |=> ($stable(posSatQ) && $stable(negSatQ)));
endmodule

bind act_sat_lut act_sat_lut_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .lookupValid (lookupValid),
  .lookupIn    (lookupIn),
  .wrEn        (wrEn),
  .wrKind      (wrKind),
  .resultValid (resultValid),
  .resultOut   (resultOut),
  .posSatQ     (posSatQ),
  .negSatQ     (negSatQ)
);

// File: tb/tb_act_sat_lut.sv
module tb_act_sat_lut;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 12;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int QMAX   = 64;
  localparam int NVEC   = 12;
  localparam logic [15:0] VEC_IN [NVEC] = '{
    16'h0000, 16'h07FF, 16'hF800, 16'h0800, 16'hF7FF, 16'h7FFF,
    16'h8000, 16'h0123, 16'hFEDC, 16'h1000, 16'hE000, 16'h0400
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              lookupValid = 1'b0;
  logic [DATA_W-1:0] lookupIn = '0;
  logic              wrEn = 1'b0;
  logic [1:0]        wrKind = 2'b00;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic              resultValid;
  logic [DATA_W-1:0] resultOut;

  act_sat_lut dut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupIn(lookupIn),
    .wrEn(wrEn), .wrKind(wrKind), .wrAddr(wrAddr), .wrData(wrData),
    .resultValid(resultValid), .resultOut(resultOut)
  );

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [15:0] tblShadow [DEPTH];
  logic [15:0] posM = 16'h0100;
  logic [15:0] negM = 16'hFF00;

  logic [15:0] expQ [QMAX];
  string       tagQ [QMAX];
  int          sentQ [QMAX];
  int          wrPtr = 0;
  int          rdPtr = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] refFn(input logic [11:0] a);
    return ({4'h0, a} * 16'd7) ^ 16'hA5A5;
  endfunction

  function automatic logic [15:0] expectOf(input logic [15:0] v);
    if (&v[15:11] || ~|v[15:11]) return tblShadow[v[11:0]];
    return v[15] ? negM : posM;
  endfunction

  function automatic string tagOf(input logic [15:0] v);
    if (&v[15:11] || ~|v[15:11]) return "R2";
    return v[15] ? "R4" : "R3";
  endfunction

  // one cycle of stimulus, driven at the falling edge
  task automatic doCycle(input logic lv, input logic [15:0] inV, input logic we,
                         input logic [1:0] kind, input logic [11:0] addr,
                         input logic [15:0] data, input logic [15:0] expV,
                         input string tag);
    @(negedge clk);
    lookupValid = lv; lookupIn = inV; wrEn = we; wrKind = kind;
    wrAddr = addr; wrData = data;
    if (lv) begin
      expQ[wrPtr] = expV; tagQ[wrPtr] = tag; sentQ[wrPtr] = cyc;
      wrPtr++;
    end
  endtask

  task automatic look(input logic [15:0] inV, input string tag);
    doCycle(1'b1, inV, 1'b0, 2'b00, 12'h0, 16'h0, expectOf(inV), tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) doCycle(1'b0, 16'h0, 1'b0, 2'b00, 12'h0, 16'h0, 16'h0, "");
  endtask

  // monitor: compares results in order and measures latency (R5, R6)
  always @(negedge clk) begin
    if (rstN && resultValid) begin
      if (rdPtr >= wrPtr) begin
        check(1'b0, "R5 unexpected resultValid", 1, 0);
      end else begin
        check(resultOut == expQ[rdPtr], tagQ[rdPtr], int'(resultOut), int'(expQ[rdPtr]));
        check(cyc - sentQ[rdPtr] == 2, "R5 latency", cyc - sentQ[rdPtr], 2);
        rdPtr++;
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(resultValid == 1'b0, "R1 valid low in reset", int'(resultValid), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(resultValid == 1'b0, "R1 valid low after reset", int'(resultValid), 0);

    // defaults of saturation values, table not yet loaded
    look(16'h7FFF, "R1 R3 default positive saturation");
    look(16'h8000, "R1 R4 default negative saturation");
    idle(4);

    // load table and saturation values
    for (int a = 0; a < DEPTH; a++) begin
      doCycle(1'b0, 16'h0, 1'b1, 2'b00, 12'(a), refFn(12'(a)), 16'h0, "");
      tblShadow[a] = refFn(12'(a));
    end
    doCycle(1'b0, 16'h0, 1'b1, 2'b01, 12'h0, 16'h7F00, 16'h0, "");
    posM = 16'h7F00;
    doCycle(1'b0, 16'h0, 1'b1, 2'b10, 12'h0, 16'h8100, 16'h0, "");
    negM = 16'h8100;

    // vector table walked back to back (R2 R3 R4 R6)
    for (int i = 0; i < NVEC; i++) look(VEC_IN[i], tagOf(VEC_IN[i]));
    idle(4);
    check(resultValid == 1'b0, "R5 idle after burst", int'(resultValid), 0);

    // reserved write kind has no effect (R7)
    doCycle(1'b0, 16'h0, 1'b1, 2'b11, 12'h005, 16'h1234, 16'h0, "");
    look(16'h7FFF, "R7 positive saturation kept");
    look(16'h8000, "R7 negative saturation kept");
    look(16'h0005, "R7 table entry kept");
    idle(3);

    // same-cycle write and lookup return old contents (R8)
    doCycle(1'b1, 16'h0010, 1'b1, 2'b00, 12'h010, 16'hBEEF, tblShadow[12'h010], "R8 old table entry");
    tblShadow[12'h010] = 16'hBEEF;
    look(16'h0010, "R8 new table entry");
    doCycle(1'b1, 16'h4000, 1'b1, 2'b01, 12'h0, 16'h6000, posM, "R8 old positive saturation");
    posM = 16'h6000;
    look(16'h4000, "R8 new positive saturation");
    doCycle(1'b1, 16'hC000, 1'b1, 2'b10, 12'h0, 16'h9000, negM, "R8 old negative saturation");
    negM = 16'h9000;
    look(16'hC000, "R8 new negative saturation");
    idle(4);

    check(rdPtr == wrPtr, "R6 all results returned", rdPtr, wrPtr);
    check(resultValid == 1'b0, "R5 idle at end", int'(resultValid), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule